// File: doc/BRIEF.md
# Signed/Unsigned Bit Field Extractor

This block pulls a contiguous run of bits out of a source word and returns it right-aligned. The caller supplies the source word, a start position, a field length, a selector for a 32-bit or 64-bit operation and a selector for signed or unsigned extraction. The result is registered. It appears one clock after the input strobe and is marked by a result-valid flag.

In unsigned mode, every result bit above the field is cleared. In signed mode, those bits are filled with a sign bit. The sign bit is read from the field's top bit, and that index is clamped to the operand's most significant bit. A zero-length field always has a sign of zero. Only the low byte of the position and length operands has any effect.

A two-state controller tracks the output register. It has two states. ST_EMPTY means no fresh result is on the output. ST_LOADED means the result from the previous cycle's strobe is on the output. The transitions are:
- ST_EMPTY→ST_LOADED and ST_LOADED→ST_LOADED happen on a strobe.
- ST_LOADED→ST_EMPTY and ST_EMPTY→ST_EMPTY happen when there is no strobe.

Top module: `bfx_unit`

## Requirements
- R1: Only bits [7:0] of `pos_opnd` and bits [7:0] of `len_opnd` affect the result; higher bits are ignored.
- R2: With `signed_sel`=0, the result equals the operand shifted right by the position, with all bits at index `length` and above cleared.
- R3: With `signed_sel`=1 and length nonzero, the sign bit is source bit min(position+length-1, MSB). MSB is 31 when `wide_sel`=0 and 63 when `wide_sel`=1.
- R4: A length of zero yields an all-zero result in both modes.
- R5: With `signed_sel`=1 and a sign bit of 1, every result bit from index `length` up to the operand MSB is set to one. The bits below `length` are the shifted source bits.
- R6: A length equal to or above the operand width (32 or 64) passes the shifted value through unmasked. In that case there are no fill bits.
- R7: A position equal to or above the operand width gives a shifted value of zero. An unsigned result is then zero, and a signed result contains only fill bits.
- R8: With `wide_sel`=0, only `src_data[31:0]` is used and `res_data[63:32]` is zero.
- R9: `res_valid` is high exactly in the cycle after each cycle with `in_valid` high. `res_data` is updated only on a strobe and holds its value otherwise. After reset, `res_valid` is 0 and `res_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| src_data | input | 64 | Source operand |
| pos_opnd | input | 32 | Start position operand (low byte used) |
| len_opnd | input | 32 | Field length operand (low byte used) |
| wide_sel | input | 1 | 1: 64-bit operation, 0: 32-bit operation |
| signed_sel | input | 1 | 1: sign-fill above field, 0: zero-fill |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_data | output | 64 | Extracted, right-aligned field |

## Verification
Every result is due exactly one clock edge after its strobe, and no other latency is legal. The bench drives its inputs on the falling edge. On the next falling edge, it compares both `res_valid` and `res_data` against the value its model predicted for the stimulus just applied. On idle cycles, it checks that `res_valid` is low and that `res_data` still holds the last result. Back-to-back strobes are used to confirm that each result replaces the previous one after exactly one cycle.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } bfx_state_e;
endpackage

// File: rtl/bfx_shift.sv
// Right shift of the (already width-trimmed) source by the position byte.
module bfx_shift #(
    parameter int DATA_W = 64,
    parameter int SEL_W  = 8
) (
    input  logic [DATA_W-1:0] src,
    input  logic [SEL_W-1:0]  pos,
    output logic [DATA_W-1:0] shifted
);
    always_comb begin
        if (int'(pos) >= DATA_W) shifted = '0;
        else                     shifted = src >> pos;
    end
endmodule

// File: rtl/bfx_signsel.sv
// Picks the fill bit: source bit at min(pos+len-1, msb), zero for len == 0.
module bfx_signsel #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int SEL_W    = 8
) (
    input  logic [DATA_W-1:0] src,
    input  logic [SEL_W-1:0]  pos,
    input  logic [SEL_W-1:0]  len,
    input  logic              wide,
    input  logic              is_signed,
    output logic              fill_bit
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int SUM_W = SEL_W + 1;

    logic [SUM_W-1:0] top_sum;
    logic [SUM_W-1:0] msb_idx;
    logic [IDX_W-1:0] pick;

    always_comb begin
        top_sum = {1'b0, pos} + {1'b0, len} - SUM_W'(1);
        msb_idx = wide ? SUM_W'(DATA_W - 1) : SUM_W'(NARROW_W - 1);
        if (top_sum > msb_idx) pick = msb_idx[IDX_W-1:0];
        else                   pick = top_sum[IDX_W-1:0];
        if (!is_signed || len == '0) fill_bit = 1'b0;
        else                         fill_bit = src[pick];
    end
endmodule

// File: rtl/bfx_fill.sv
// Keeps the low len bits of the shifted word, fills the rest up to the
// operand MSB with the fill bit, and clears lanes outside the operand.
module bfx_fill #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int SEL_W    = 8
) (
    input  logic [DATA_W-1:0] shifted,
    input  logic [SEL_W-1:0]  len,
    input  logic              wide,
    input  logic              fill_bit,
    output logic [DATA_W-1:0] result
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic keep;
        logic in_lane;
        assign keep = int'(len) > b;
        if (b < NARROW_W) begin : g_low
            assign in_lane = 1'b1;
        end else begin : g_high
            assign in_lane = wide;
        end
        assign result[b] = in_lane & (keep ? shifted[b] : fill_bit);
    end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int OPND_W   = 32,
    parameter int SEL_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic [OPND_W-1:0] pos_opnd,
    input  logic [OPND_W-1:0] len_opnd,
    input  logic              wide_sel,
    input  logic              signed_sel,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    import bfx_pkg::*;

    localparam int HI_W = DATA_W - NARROW_W;

    bfx_state_e        state_q, state_d;
    logic [SEL_W-1:0]  pos_b, len_b;
    logic [DATA_W-1:0] src_trim, shifted, next_res;
    logic              fill_bit;

    assign pos_b    = pos_opnd[SEL_W-1:0];
    assign len_b    = len_opnd[SEL_W-1:0];
    assign src_trim = wide_sel ? src_data : {{HI_W{1'b0}}, src_data[NARROW_W-1:0]};

    bfx_shift #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_shift (
        .src(src_trim), .pos(pos_b), .shifted(shifted)
    );

    bfx_signsel #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .SEL_W(SEL_W)) u_sign (
        .src(src_trim), .pos(pos_b), .len(len_b), .wide(wide_sel),
        .is_signed(signed_sel), .fill_bit(fill_bit)
    );

    bfx_fill #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .SEL_W(SEL_W)) u_fill (
        .shifted(shifted), .len(len_b), .wide(wide_sel),
        .fill_bit(fill_bit), .result(next_res)
    );

    always_comb begin
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        res_data <= '0;
        else if (in_valid) res_data <= next_res;
    end

    assign res_valid = (state_q == ST_LOADED);
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int OPND_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OPND_W-1:0] pos_opnd,
    input logic [OPND_W-1:0] len_opnd,
    input logic              wide_sel,
    input logic              signed_sel,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data
);
    logic [7:0] pos_lo, len_lo;
    int         width_now;
    assign pos_lo    = pos_opnd[7:0];
    assign len_lo    = len_opnd[7:0];
    assign width_now = wide_sel ? DATA_W : NARROW_W;

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    p_valid_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_data));
    p_len_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && len_lo == 8'd0) |=> res_data == '0);
    p_narrow_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_sel) |=> res_data[DATA_W-1:NARROW_W] == '0);
    p_unsigned_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !signed_sel) |=> (res_data >> $past(len_lo)) == '0);
    p_pos_beyond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !signed_sel && int'(pos_lo) >= width_now) |=> res_data == '0);
endmodule

bind bfx_unit bfx_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .OPND_W(OPND_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pos_opnd(pos_opnd),
    .len_opnd(len_opnd), .wide_sel(wide_sel), .signed_sel(signed_sel),
    .res_valid(res_valid), .res_data(res_data)
);

// File: tb/bfx_unit_test.sv
`timescale 1ns/1ps
module bfx_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src_data = '0;
    logic [31:0] pos_opnd = '0, len_opnd = '0;
    logic        wide_sel = 1'b0, signed_sel = 1'b0;
    logic        res_valid;
    logic [63:0] res_data;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    bit          exp_valid = 0;
    logic [63:0] exp_data = '0;
    string       exp_tag = "R9 reset";

    always #2 clk = ~clk;

    bfx_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_data(src_data),
        .pos_opnd(pos_opnd), .len_opnd(len_opnd), .wide_sel(wide_sel),
        .signed_sel(signed_sel), .res_valid(res_valid), .res_data(res_data)
    );

    // Behavioural model: walk the field bit by bit.
    function automatic logic [63:0] model(logic [63:0] d, logic [31:0] p, logic [31:0] l,
                                          bit wide, bit sgn);
        int w  = wide ? 64 : 32;
        int pp = int'(p & 32'hFF);
        int ll = int'(l & 32'hFF);
        int top = pp + ll - 1;
        bit s;
        logic [63:0] r = '0;
        if (top > w - 1) top = w - 1;
        s = (sgn && ll != 0) ? d[top] : 1'b0;
        for (int i = 0; i < w; i++) begin
            if (i < ll) r[i] = (pp + i < w) ? d[pp + i] : 1'b0;
            else        r[i] = s;
        end
        return r;
    endfunction

    task automatic compare();
        n_cmp++;
        if (res_valid !== exp_valid || res_data !== exp_data) begin
            n_bad++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     exp_tag, res_valid, res_data, exp_valid, exp_data);
        end
    endtask

    task automatic step(bit v, logic [63:0] d, logic [31:0] p, logic [31:0] l,
                        bit w, bit s, string tag);
        @(negedge clk);
        compare();
        in_valid = v; src_data = d; pos_opnd = p; len_opnd = l;
        wide_sel = w; signed_sel = s;
        exp_valid = v;
        if (v) exp_data = model(d, p, l, w, s);
        exp_tag = tag;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state checked by the first step
        step(1, 64'hDEADBEEF_12345678, 32'd4, 32'd8, 0, 0, "R2 narrow unsigned");
        step(1, 64'hFEDC_BA98_7654_3210, 32'd36, 32'd12, 1, 0, "R2 wide unsigned");
        step(1, 64'hDEADBEEF_12345678, 32'hABCD_0004, 32'h5555_0008, 0, 0, "R1 high bits ignored");
        step(1, 64'h0000_0000_0000_00F0, 32'd4, 32'd4, 0, 1, "R5 sign fill narrow");
        step(1, 64'h8000_0000_0000_0F00, 32'd8, 32'd4, 1, 1, "R5 sign fill wide");
        step(1, 64'h0000_0000_0000_0070, 32'd4, 32'd4, 0, 1, "R3 sign zero");
        step(1, 64'h0000_0000_8000_0000, 32'd28, 32'd10, 0, 1, "R3 clamp narrow");
        step(1, 64'h8000_0000_0000_0000, 32'd60, 32'd20, 1, 1, "R3 clamp wide");
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 32'd5, 32'd0, 1, 1, "R4 len zero signed");
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 32'd5, 32'h100, 0, 0, "R4 len zero unsigned");
        step(1, 64'hF123_4567_89AB_CDEF, 32'd8, 32'd64, 1, 0, "R6 len full wide");
        step(1, 64'h0000_0000_F234_5678, 32'd4, 32'd200, 0, 1, "R6 len over narrow signed");
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 32'd40, 32'd4, 0, 0, "R7 pos over narrow unsigned");
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 32'd70, 32'd4, 1, 0, "R7 pos over wide unsigned");
        step(1, 64'h0000_0000_8000_0000, 32'd40, 32'd4, 0, 1, "R7 pos over narrow signed");
        step(1, 64'hAAAA_5555_0000_8000, 32'd12, 32'd8, 0, 1, "R8 narrow upper zero");
        step(0, 64'h1234_5678_9ABC_DEF0, 32'd0, 32'd16, 1, 0, "R9 idle hold");
        step(0, 64'h0, 32'd0, 32'd0, 0, 0, "R9 idle hold 2");
        step(1, 64'h0000_0000_0000_ABCD, 32'd0, 32'd16, 1, 0, "R9 back to back a");
        step(1, 64'h0000_0000_0000_ABCD, 32'd4, 32'd8, 1, 0, "R9 back to back b");
        step(0, 64'h0, 32'd0, 32'd0, 0, 0, "R9 drop");
        @(negedge clk);
        compare();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule